// File: doc/BRIEF.md
# Command-list I/O processor

This block takes work off the CPU for word-sized moves between a small set of device ports and main memory. The CPU hands it one short instruction. The instruction names what to do, which device port to use and where a command block sits in memory. The engine reads that four-word block itself and decodes it. It then streams the counted words in one of two directions. Each word access goes through a request/grant port that the engine shares with the CPU, so every word costs exactly one stolen memory cycle.

When the command has run to the end, or has been refused, the engine raises a one-cycle interrupt pulse with an error flag beside it. An instruction that arrives while the engine is still working is turned away with a one-cycle reject flag. It leaves the transfer in flight untouched. Memory addresses count words, not bytes.

Top module: `cmd_iop`

## Requirements
- R1: An instruction offered with `instr_valid` while idle, with `instr_op` equal to 1 (run), is accepted. The engine then reads four words from `instr_addr`, `instr_addr+1`, `instr_addr+2` and `instr_addr+3`. It decodes them in that order as: opcode, data address, word count, special-request word.
- R2: Every memory access needs its own grant. While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady into the next cycle. A granted cycle completes exactly one word.
- R3: Opcode 0 (device to memory) moves `count` words. Each word comes from the selected device's input data and is written to memory with `mem_we` high. Writes start at the data address and rise by one per word. Each word is consumed from the device by a one-cycle `dev_in_pop` in the same cycle as its write grant.
- R4: Opcode 1 (memory to device) reads `count` words from the data address upward. Each word read is presented on `dev_out_data`, with the selected `dev_out_valid` bit high, and is held until that device's `dev_out_ready` is seen.
- R5: When bit 0 of the special-request word is 1, the data address stays fixed for the whole transfer instead of incrementing. This holds in both directions.
- R6: An opcode other than 0 or 1 moves no data. After the fetch the engine completes with `irq_err` set.
- R7: A count of 0 with a valid opcode moves no data and completes with `irq_err` clear.
- R8: Completion is a one-cycle `irq` pulse, with `irq_err` valid in the same cycle. Each accepted or refused instruction produces exactly one pulse.
- R9: An instruction whose `instr_op` is not 1 is refused without any memory access. The engine completes the next cycle with `irq_err` set.
- R10: `busy` is high from the cycle after acceptance through the `irq` cycle. An instruction offered while busy raises `instr_reject` for one cycle after it and is otherwise ignored: it makes no extra `irq` and does not change the device or addresses in use.
- R11: After reset the engine is idle. `busy`, `irq`, `instr_reject`, `mem_req` and all `dev_out_valid` bits are low.
- R12: Only the device port named by the instruction sees a `dev_in_pop` or `dev_out_valid` bit. At most one such bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | CPU offers an instruction this cycle |
| instr_op | input | 2 | Instruction operation, 1 = run the command block |
| instr_dev | input | DEVW | Target device port index |
| instr_addr | input | AW | Word address of the command block |
| busy | output | 1 | Engine is working on an instruction |
| instr_reject | output | 1 | Previous cycle's instruction was refused as busy |
| irq | output | 1 | One-cycle completion interrupt |
| irq_err | output | 1 | Completion ended in error (valid with irq) |
| mem_req | output | 1 | Memory cycle requested |
| mem_we | output | 1 | Requested cycle is a write |
| mem_addr | output | AW | Word address of the memory cycle |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory cycle granted this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| dev_in_valid | input | NDEV | Device has a word for memory |
| dev_in_data | input | NDEV*32 | Per-device input words, device d in bits d*32 upward |
| dev_in_pop | output | NDEV | Device word consumed this cycle |
| dev_out_valid | output | NDEV | Word offered to device |
| dev_out_data | output | 32 | Word offered to the selected device |
| dev_out_ready | input | NDEV | Device takes the offered word |

## Verification
The transfer loop is driven under a grant pattern that withholds one memory cycle in three and a ready pattern that stalls one cycle in four. This shows that stalls neither drop nor duplicate words. Device-to-memory and memory-to-device runs go to different ports, each with incrementing and with fixed addresses. These separate the direction decode, the address step and the port steering. Bad opcode, zero count and a refused instruction are told apart by the number of memory grants each consumes (four, four and none) together with the error flag. A second instruction injected mid-transfer shows that the reject path leaves the running command's words and its single interrupt intact.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int WORD_W    = 32;
    localparam int CMD_WORDS = 4;

    // instruction operation that starts a command block
    localparam logic [1:0] INSTR_RUN = 2'd1;

    // command opcodes
    localparam logic [WORD_W-1:0] OPC_D2M = 32'd0;
    localparam logic [WORD_W-1:0] OPC_M2D = 32'd1;

    // special-request bit: keep data address fixed
    localparam int SPC_FIXED_BIT = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_D2M,
        S_M2D_RD,
        S_M2D_PUSH,
        S_DONE
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] opcode;
        logic [WORD_W-1:0] daddr;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] special;
    } cmd_blk_t;

    function automatic logic opc_known(input logic [WORD_W-1:0] opc);
        return (opc == OPC_D2M) || (opc == OPC_M2D);
    endfunction

endpackage

// File: rtl/iop_cmd_store.sv
module iop_cmd_store
    import iop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] word,
    output cmd_blk_t          cmd
);

    for (genvar i = 0; i < CMD_WORDS; i++) begin : g_slot
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr && idx == 2'(i))
                q <= word;
        end
    end

    // block layout: word 0 opcode, 1 data address, 2 count, 3 special
    assign cmd.opcode  = g_slot[0].q;
    assign cmd.daddr   = g_slot[1].q;
    assign cmd.count   = g_slot[2].q;
    assign cmd.special = g_slot[3].q;

endmodule

// File: rtl/iop_dev_sel.sv
module iop_dev_sel
    import iop_pkg::*;
#(
    parameter int NDEV = 4,
    parameter int DEVW = 2
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DEVW-1:0]        sel,
    input  logic                   pop_en,
    input  logic                   out_en,
    input  logic [NDEV-1:0]        in_valid,
    input  logic [NDEV*WORD_W-1:0] in_data,
    input  logic [NDEV-1:0]        out_ready,
    output logic                   sel_in_valid,
    output logic [WORD_W-1:0]      sel_in_data,
    output logic                   sel_out_ready,
    output logic [NDEV-1:0]        in_pop,
    output logic [NDEV-1:0]        out_valid
);

    for (genvar g = 0; g < NDEV; g++) begin : g_port
        assign in_pop[g]    = pop_en && (sel == DEVW'(g));
        assign out_valid[g] = out_en && (sel == DEVW'(g));
    end

    assign sel_in_valid  = in_valid[sel];
    assign sel_in_data   = in_data[sel*WORD_W +: WORD_W];
    assign sel_out_ready = out_ready[sel];

    // R12: a single port strobed at a time
    p_pop_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_pop));
    p_out_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

endmodule

// File: rtl/iop_engine.sv
module iop_engine
    import iop_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DEVW = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [1:0]        instr_op,
    input  logic [DEVW-1:0]   instr_dev,
    input  logic [AW-1:0]     instr_addr,
    output logic              busy,
    output logic              instr_reject,
    output logic              irq,
    output logic              irq_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  cmd_blk_t          cmd,
    output logic              cmd_wr,
    output logic [1:0]        cmd_idx,
    output logic [WORD_W-1:0] cmd_word,
    output logic [DEVW-1:0]   dev_sel,
    output logic              pop_en,
    output logic              out_en,
    input  logic              sel_in_valid,
    input  logic [WORD_W-1:0] sel_in_data,
    input  logic              sel_out_ready,
    output logic [WORD_W-1:0] out_data
);

    eng_state_e        state;
    logic [1:0]        idx;
    logic [AW-1:0]     cmd_base;
    logic [AW-1:0]     cur_addr;
    logic [DEVW-1:0]   dev_q;
    logic [WORD_W-1:0] remain;
    logic [WORD_W-1:0] buf_q;
    logic              err_q;
    logic              reject_q;

    logic              step_fixed;
    logic [AW-1:0]     next_addr;
    logic              last_word;
    logic              unused_cmd_bits;

    assign step_fixed      = cmd.special[SPC_FIXED_BIT];
    assign next_addr       = step_fixed ? cur_addr : cur_addr + AW'(1);
    assign last_word       = (remain == WORD_W'(1));
    assign unused_cmd_bits = ^{cmd.daddr[WORD_W-1:AW], cmd.special[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            idx      <= '0;
            cmd_base <= '0;
            cur_addr <= '0;
            dev_q    <= '0;
            remain   <= '0;
            buf_q    <= '0;
            err_q    <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= instr_valid && (state != S_IDLE);
            case (state)
                S_IDLE: if (instr_valid) begin
                    dev_q    <= instr_dev;
                    cmd_base <= instr_addr;
                    idx      <= '0;
                    if (instr_op == INSTR_RUN) begin
                        err_q <= 1'b0;
                        state <= S_FETCH;
                    end else begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end
                end
                S_FETCH: if (mem_gnt) begin
                    idx <= idx + 2'd1;
                    if (idx == 2'd3) state <= S_DECODE;
                end
                S_DECODE: begin
                    if (!opc_known(cmd.opcode)) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (cmd.count == '0) begin
                        state <= S_DONE;
                    end else begin
                        cur_addr <= cmd.daddr[AW-1:0];
                        remain   <= cmd.count;
                        state    <= (cmd.opcode == OPC_D2M) ? S_D2M : S_M2D_RD;
                    end
                end
                S_D2M: if (sel_in_valid && mem_gnt) begin
                    cur_addr <= next_addr;
                    remain   <= remain - WORD_W'(1);
                    if (last_word) state <= S_DONE;
                end
                S_M2D_RD: if (mem_gnt) begin
                    buf_q <= mem_rdata;
                    state <= S_M2D_PUSH;
                end
                S_M2D_PUSH: if (sel_out_ready) begin
                    cur_addr <= next_addr;
                    remain   <= remain - WORD_W'(1);
                    state    <= last_word ? S_DONE : S_M2D_RD;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy         = (state != S_IDLE);
    assign instr_reject = reject_q;
    assign irq          = (state == S_DONE);
    assign irq_err      = err_q;

    assign mem_req   = (state == S_FETCH) || (state == S_M2D_RD) ||
                       ((state == S_D2M) && sel_in_valid);
    assign mem_we    = (state == S_D2M);
    assign mem_addr  = (state == S_FETCH) ? cmd_base + AW'(idx) : cur_addr;
    assign mem_wdata = (state == S_D2M) ? sel_in_data : '0;

    assign cmd_wr   = (state == S_FETCH) && mem_gnt;
    assign cmd_idx  = idx;
    assign cmd_word = mem_rdata;

    assign dev_sel  = dev_q;
    assign pop_en   = (state == S_D2M) && sel_in_valid && mem_gnt;
    assign out_en   = (state == S_M2D_PUSH);
    assign out_data = buf_q;

    // R2: an ungranted request is held unchanged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));
    // R4: an offered device word stays until taken
    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
        out_en && !sel_out_ready |=> out_en && $stable(out_data));
    // R8: completion is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R10: only a busy engine rejects
    p_reject_busy_r10: assert property (@(posedge clk) disable iff (rst)
        instr_reject |-> $past(busy));
    // R11: no memory traffic while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

endmodule

// File: rtl/cmd_iop.sv
module cmd_iop
    import iop_pkg::*;
#(
    parameter int  NDEV = 4,
    parameter int  AW   = 12,
    localparam int DEVW = $clog2(NDEV)
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   instr_valid,
    input  logic [1:0]             instr_op,
    input  logic [DEVW-1:0]        instr_dev,
    input  logic [AW-1:0]          instr_addr,
    output logic                   busy,
    output logic                   instr_reject,
    output logic                   irq,
    output logic                   irq_err,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [WORD_W-1:0]      mem_wdata,
    input  logic                   mem_gnt,
    input  logic [WORD_W-1:0]      mem_rdata,
    input  logic [NDEV-1:0]        dev_in_valid,
    input  logic [NDEV*WORD_W-1:0] dev_in_data,
    output logic [NDEV-1:0]        dev_in_pop,
    output logic [NDEV-1:0]        dev_out_valid,
    output logic [WORD_W-1:0]      dev_out_data,
    input  logic [NDEV-1:0]        dev_out_ready
);

    cmd_blk_t          cmd;
    logic              cmd_wr;
    logic [1:0]        cmd_idx;
    logic [WORD_W-1:0] cmd_word;
    logic [DEVW-1:0]   dev_sel;
    logic              pop_en;
    logic              out_en;
    logic              sel_in_valid;
    logic [WORD_W-1:0] sel_in_data;
    logic              sel_out_ready;

    iop_cmd_store u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (cmd_wr),
        .idx  (cmd_idx),
        .word (cmd_word),
        .cmd  (cmd)
    );

    iop_dev_sel #(.NDEV(NDEV), .DEVW(DEVW)) u_sel (
        .clk           (clk),
        .rst           (rst),
        .sel           (dev_sel),
        .pop_en        (pop_en),
        .out_en        (out_en),
        .in_valid      (dev_in_valid),
        .in_data       (dev_in_data),
        .out_ready     (dev_out_ready),
        .sel_in_valid  (sel_in_valid),
        .sel_in_data   (sel_in_data),
        .sel_out_ready (sel_out_ready),
        .in_pop        (dev_in_pop),
        .out_valid     (dev_out_valid)
    );

    iop_engine #(.AW(AW), .DEVW(DEVW)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .instr_op      (instr_op),
        .instr_dev     (instr_dev),
        .instr_addr    (instr_addr),
        .busy          (busy),
        .instr_reject  (instr_reject),
        .irq           (irq),
        .irq_err       (irq_err),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rdata     (mem_rdata),
        .cmd           (cmd),
        .cmd_wr        (cmd_wr),
        .cmd_idx       (cmd_idx),
        .cmd_word      (cmd_word),
        .dev_sel       (dev_sel),
        .pop_en        (pop_en),
        .out_en        (out_en),
        .sel_in_valid  (sel_in_valid),
        .sel_in_data   (sel_in_data),
        .sel_out_ready (sel_out_ready),
        .out_data      (dev_out_data)
    );

endmodule

// File: tb/test_cmd_iop.sv
module test_cmd_iop;

    localparam int NDEV = 4;
    localparam int AW   = 12;
    localparam int DEVW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic               instr_valid = 1'b0;
    logic [1:0]         instr_op = '0;
    logic [DEVW-1:0]    instr_dev = '0;
    logic [AW-1:0]      instr_addr = '0;
    logic               busy, instr_reject, irq, irq_err;
    logic               mem_req, mem_we;
    logic [AW-1:0]      mem_addr;
    logic [31:0]        mem_wdata;
    logic               mem_gnt = 1'b0;
    logic [31:0]        mem_rdata = '0;
    logic [NDEV-1:0]    dev_in_valid = '1;
    logic [NDEV*32-1:0] dev_in_data;
    logic [NDEV-1:0]    dev_in_pop, dev_out_valid;
    logic [31:0]        dev_out_data;
    logic [NDEV-1:0]    dev_out_ready = '0;

    cmd_iop #(.NDEV(NDEV), .AW(AW)) i_cmd_iop (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_dev(instr_dev), .instr_addr(instr_addr),
        .busy(busy), .instr_reject(instr_reject),
        .irq(irq), .irq_err(irq_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_pop(dev_in_pop), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    int total = 0;
    int bad   = 0;
    bit summary_done = 0;

    logic [31:0] mem [256];
    logic [63:0] exp_wr  [$];
    logic [39:0] exp_out [$];
    logic        exp_irq [$];
    logic [63:0] e_w;
    logic [39:0] e_o;
    logic        e_i;

    int nreq = 0, nirq = 0, nrej = 0, tick = 0;
    int dcnt [NDEV];
    int dexp [NDEV];
    bit adv_pend = 0;
    int adv_dev = 0;
    int cur_dev = 0;

    for (genvar d = 0; d < NDEV; d++) begin : g_src
        assign dev_in_data[d*32 +: 32] = {8'(8'hA0 + d), 8'h00, 16'(dcnt[d])};
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // device source advances after the edge where its word was taken
    initial forever begin
        @(posedge clk);
        #2;
        if (adv_pend) begin
            dcnt[adv_dev]++;
            adv_pend = 0;
        end
    end

    // monitor: memory and device models, scoreboard comparison
    always @(negedge clk) begin
        tick++;
        if (rst) begin
            mem_gnt = 1'b0;
            dev_out_ready = '0;
        end else begin
            mem_gnt = mem_req && (tick % 3 != 0);
            mem_rdata = mem[mem_addr[7:0]];
            dev_out_ready = (tick % 4 != 1) ? '1 : '0;
            if (mem_gnt) begin
                nreq++;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    adv_pend = 1;
                    adv_dev = cur_dev;
                    if (exp_wr.size() == 0)
                        chk(0, "R3 unexpected memory write", {20'b0, mem_addr, mem_wdata}, 64'h0);
                    else begin
                        e_w = exp_wr.pop_front();
                        chk({20'b0, mem_addr, mem_wdata} == e_w, "R3/R5 memory write addr,data",
                            {20'b0, mem_addr, mem_wdata}, e_w);
                    end
                end
            end
            if ((dev_out_valid != 0) && (dev_out_ready != 0)) begin
                if (exp_out.size() == 0)
                    chk(0, "R4 unexpected device word", {28'b0, dev_out_valid, dev_out_data}, 64'h0);
                else begin
                    e_o = exp_out.pop_front();
                    chk(dev_out_valid == (NDEV'(1) << e_o[39:32]), "R12 device out steering",
                        64'(dev_out_valid), 64'(NDEV'(1) << e_o[39:32]));
                    chk(dev_out_data == e_o[31:0], "R4/R5 device out data",
                        64'(dev_out_data), 64'(e_o[31:0]));
                end
            end
            if (irq) begin
                nirq++;
                if (exp_irq.size() == 0)
                    chk(0, "R8 unexpected irq", 64'(irq_err), 64'h0);
                else begin
                    e_i = exp_irq.pop_front();
                    chk(irq_err == e_i, "R8 irq_err with completion", 64'(irq_err), 64'(e_i));
                end
            end
            if (instr_reject) nrej++;
            #1;
            if (dev_in_pop != 0)
                chk(dev_in_pop == (NDEV'(1) << cur_dev), "R12 device pop steering",
                    64'(dev_in_pop), 64'(NDEV'(1) << cur_dev));
        end
    end

    task automatic put_cmd(input int base, input int opc, input int daddr, input int cnt, input int spec);
        mem[base]   = 32'(opc);
        mem[base+1] = 32'(daddr);
        mem[base+2] = 32'(cnt);
        mem[base+3] = 32'(spec);
    endtask

    task automatic expect_d2m(input int dev, input int daddr, input int cnt, input bit fixed);
        for (int i = 0; i < cnt; i++) begin
            exp_wr.push_back({20'b0, 12'(fixed ? daddr : daddr + i),
                              8'(8'hA0 + dev), 8'h00, 16'(dexp[dev])});
            dexp[dev]++;
        end
    endtask

    task automatic expect_m2d(input int dev, input int daddr, input int cnt, input bit fixed);
        for (int i = 0; i < cnt; i++)
            exp_out.push_back({8'(dev), mem[fixed ? daddr : daddr + i]});
    endtask

    task automatic issue(input logic [1:0] op, input int dev, input int addr);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = op;
        instr_dev   = DEVW'(dev);
        instr_addr  = AW'(addr);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int start = nirq;
        int n = 0;
        while (nirq == start && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(nirq != start, req, 64'(nirq), 64'(start + 1));
        repeat (3) @(negedge clk);
        chk(exp_wr.size() == 0 && exp_out.size() == 0, {req, " all expected words seen"},
            64'(exp_wr.size() + exp_out.size()), 64'h0);
    endtask

    initial begin
        int r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        for (int d = 0; d < NDEV; d++) begin dcnt[d] = 0; dexp[d] = 0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!busy, "R11 busy low after reset", 64'(busy), 64'h0);
        chk(!irq && !instr_reject, "R11 irq/reject low after reset", 64'({irq, instr_reject}), 64'h0);
        chk(!mem_req && dev_out_valid == 0, "R11 no request after reset", 64'({mem_req, dev_out_valid}), 64'h0);

        // R1 R3: device 1 to memory, incrementing
        put_cmd(8'h00, 0, 8'h40, 3, 0);
        cur_dev = 1;
        expect_d2m(1, 8'h40, 3, 0);
        exp_irq.push_back(1'b0);
        r0 = nreq;
        issue(2'd1, 1, 8'h00);
        chk(busy, "R10 busy after accept", 64'(busy), 64'h1);
        wait_done("R1 R3 d2m completion");
        chk(nreq - r0 == 7, "R2 one grant per word (4 fetch + 3 data)", 64'(nreq - r0), 64'd7);

        // R4: memory to device 2, incrementing
        for (int i = 0; i < 4; i++) mem[8'h50 + i] = 32'h5500_0000 + 32'(i);
        put_cmd(8'h04, 1, 8'h50, 4, 0);
        cur_dev = 2;
        expect_m2d(2, 8'h50, 4, 0);
        exp_irq.push_back(1'b0);
        issue(2'd1, 2, 8'h04);
        wait_done("R4 m2d completion");

        // R5: device 3 to memory, fixed address
        put_cmd(8'h08, 0, 8'h60, 3, 1);
        cur_dev = 3;
        expect_d2m(3, 8'h60, 3, 1);
        exp_irq.push_back(1'b0);
        issue(2'd1, 3, 8'h08);
        wait_done("R5 fixed d2m completion");
        chk(mem[8'h60] == 32'hA300_0002, "R5 fixed address holds last word", 64'(mem[8'h60]), 64'hA3000002);
        chk(mem[8'h61] == 32'hDEAD_0061, "R5 neighbour untouched", 64'(mem[8'h61]), 64'hDEAD0061);

        // R5: memory to device 0, fixed address
        mem[8'h70] = 32'h7777_1234;
        put_cmd(8'h0C, 1, 8'h70, 2, 1);
        cur_dev = 0;
        expect_m2d(0, 8'h70, 2, 1);
        exp_irq.push_back(1'b0);
        issue(2'd1, 0, 8'h0C);
        wait_done("R5 fixed m2d completion");

        // R6: unknown opcode
        put_cmd(8'h10, 7, 8'h40, 5, 0);
        exp_irq.push_back(1'b1);
        r0 = nreq;
        issue(2'd1, 1, 8'h10);
        wait_done("R6 bad opcode completion");
        chk(nreq - r0 == 4, "R6 only the fetch uses memory", 64'(nreq - r0), 64'd4);

        // R7: zero count
        put_cmd(8'h14, 0, 8'h40, 0, 0);
        exp_irq.push_back(1'b0);
        r0 = nreq;
        issue(2'd1, 1, 8'h14);
        wait_done("R7 zero count completion");
        chk(nreq - r0 == 4, "R7 only the fetch uses memory", 64'(nreq - r0), 64'd4);

        // R9: refused instruction operation
        exp_irq.push_back(1'b1);
        r0 = nreq;
        issue(2'd2, 1, 8'h00);
        wait_done("R9 refused op completion");
        chk(nreq == r0, "R9 no memory access", 64'(nreq - r0), 64'd0);

        // R10: instruction while busy
        put_cmd(8'h20, 0, 8'h90, 4, 0);
        put_cmd(8'h18, 1, 8'h50, 3, 0);
        cur_dev = 1;
        expect_m2d(1, 8'h50, 3, 0);
        exp_irq.push_back(1'b0);
        r0 = nrej;
        issue(2'd1, 1, 8'h18);
        repeat (2) @(negedge clk);
        issue(2'd1, 0, 8'h20);
        chk(instr_reject, "R10 reject pulse while busy", 64'(instr_reject), 64'h1);
        wait_done("R10 running transfer completes");
        repeat (40) @(negedge clk);
        chk(nrej - r0 == 1, "R10 exactly one reject", 64'(nrej - r0), 64'd1);
        chk(!busy && exp_irq.size() == 0, "R10 no second command started", 64'(busy), 64'h0);

        if (!summary_done) begin
            summary_done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

endmodule